// File: doc/BRIEF.md
# Gated Pulse-Count Converter

This block turns a pulse train, whose rate carries an analog quantity, into a digital code. It counts rising edges of an asynchronous pulse input over a gate window. The window is made by dividing the block's own master clock with a binary down-counter. The result depends only on the ratio of pulse rate to clock rate, so clock drift cancels. A host writes the window length in master clocks and pulses `start`. When the window closes, the block latches the raw edge count. It also produces a corrected code: the raw count minus the count a zero-scale input gives (one twentieth of the window length), floored at zero. A one-cycle `done` strobe marks the new values.

A window length that is a whole number of interferer periods rejects that interferer. For example, 100 ms covers whole periods of both 50 Hz and 60 Hz. For N-code resolution the window must last at least N divided by the full-scale pulse rate. The full-scale count is the window length multiplied by the full-scale rate.

The control is a three-state machine:
- `ST_IDLE` goes to `ST_GATE` (transition *arm*) on a sampled `start`.
- `ST_GATE` goes to `ST_LATCH` (transition *close*) when the divider reaches its last cycle, and otherwise stays in `ST_GATE` (transition *hold*). A `start` seen in this state does nothing.
- `ST_LATCH` goes to `ST_IDLE` (transition *report*), and the results are registered on that step.

Top module: `gated_count_conv`

## Requirements
- R1: After reset, `raw_count`, `result`, `overflow` and `done` are all 0.
- R2: A `start` sampled high in idle opens a window of exactly `gate_len` master clocks. `done` is high in the cycle that follows the (gate_len+1)-th rising clock edge after the edge that accepted `start`.
- R3: Only rising edges of `pulse_in` seen while the window is open are counted. For a pulse period of P clocks, `raw_count` is floor(gate_len/P) within plus or minus one.
- R4: `result` equals `raw_count` minus floor(gate_len/20), and is 0 when that difference would be negative.
- R5: `done` is high for exactly one clock. `raw_count`, `result` and `overflow` take their new values in that same cycle.
- R6: A `start` asserted while a conversion is running is ignored: the running window keeps its length and only one `done` is produced.
- R7: If more edges arrive than `raw_count` can hold, the count saturates at 2^CNT_W-1 and `overflow` is 1 with that result.
- R8: `gate_len` is captured when `start` is accepted, so later changes do not affect the running window. A `gate_len` of 0 is treated as 1.
- R9: A `start` asserted in the same cycle as `done` is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; also the timebase of the gate window |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion; sampled only in idle |
| pulse_in | input | 1 | Asynchronous pulse train to be counted |
| gate_len | input | GATE_W | Window length in master clocks |
| raw_count | output | CNT_W | Edge count of the last window (saturating) |
| result | output | CNT_W | Raw count less the zero-scale count, floored at 0 |
| overflow | output | 1 | The last window's count saturated |
| done | output | 1 | One-cycle strobe marking new results |

## Verification
Two events can land in the same cycle: the `done` report of one conversion and the `start` of the next. The test raises `start` in the very cycle where `done` is seen high. It then checks that the second conversion is accepted, and that its `done` arrives exactly gate_len+1 edges later. A second collision pairs an open window with a repeated `start` and a changed `gate_len`. That case is judged by the cycle at which `done` arrives and by the absence of any second strobe.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_LATCH = 2'd2
    } conv_state_t;
endpackage

// File: rtl/gcc_sync_edge.sv
module gcc_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Compare the newest synchronised sample with the one before it.
    assign rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

    // R3: a detected edge can never be followed by another edge in the next cycle
    assert_rise_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/gcc_gate_timer.sv
module gcc_gate_timer #(
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [GATE_W-1:0] len,
    output logic              open,
    output logic              last
);
    logic [GATE_W-1:0] remain_q;

    // Binary down-counter clocked by the master clock; 0 loads as 1 (R8).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain_q <= '0;
        else if (load)
            remain_q <= (len == '0) ? GATE_W'(1) : len;
        else if (remain_q != '0)
            remain_q <= remain_q - GATE_W'(1);
    end

    assign open = (remain_q != '0);
    assign last = (remain_q == GATE_W'(1));

    // R2: the window shrinks by exactly one clock per cycle
    assert_gate_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remain_q > GATE_W'(1)) |=> (remain_q == $past(remain_q) - GATE_W'(1)));

    // R2: the window closes right after its last cycle unless reloaded
    assert_gate_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !open);
endmodule

// File: rtl/gcc_edge_tally.sv
module gcc_edge_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (clr) begin
            count <= '0;
            sat   <= 1'b0;
        end else if (inc) begin
            if (count == CNT_MAX) sat   <= 1'b1;
            else                  count <= count + CNT_W'(1);
        end
    end

    // R7: a full counter never wraps
    assert_tally_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

    // R7: the saturation flag only ever accompanies a full counter
    assert_tally_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> (count == CNT_MAX));
endmodule

// File: rtl/gated_count_conv.sv
module gated_count_conv
    import gcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int GATE_W      = 20,
    parameter int ZS_DIV      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pulse_in,
    input  logic [GATE_W-1:0] gate_len,
    output logic [CNT_W-1:0]  raw_count,
    output logic [CNT_W-1:0]  result,
    output logic              overflow,
    output logic              done
);
    localparam int W_CMP = (GATE_W > CNT_W) ? GATE_W : CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    conv_state_t state_q, state_d;

    logic              pulse_rise;
    logic              gate_load;
    logic              gate_open;
    logic              gate_last;
    logic [GATE_W-1:0] len_q;
    logic [CNT_W-1:0]  tally;
    logic              tally_sat;
    logic [GATE_W-1:0] zero_cnt;
    logic [W_CMP-1:0]  tally_x;
    logic [W_CMP-1:0]  zero_x;
    logic [CNT_W-1:0]  corrected;

    gcc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise     (pulse_rise)
    );

    gcc_gate_timer #(.GATE_W(GATE_W)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gate_load),
        .len   (gate_len),
        .open  (gate_open),
        .last  (gate_last)
    );

    gcc_edge_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gate_load),
        .inc   (pulse_rise & gate_open),
        .count (tally),
        .sat   (tally_sat)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        gate_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    gate_load = 1'b1;      // arm
                    state_d   = ST_GATE;
                end
            end
            ST_GATE: begin
                if (gate_last) state_d = ST_LATCH;   // close; else hold
            end
            ST_LATCH: state_d = ST_IDLE;             // report
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured window length (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         len_q <= '0;
        else if (gate_load) len_q <= (gate_len == '0) ? GATE_W'(1) : gate_len;
    end

    // Zero-scale correction: raw minus one twentieth of the window, floored at 0
    always_comb begin
        zero_cnt  = len_q / GATE_W'(ZS_DIV);
        tally_x   = W_CMP'(tally);
        zero_x    = W_CMP'(zero_cnt);
        corrected = (tally_x > zero_x) ? CNT_W'(tally_x - zero_x) : '0;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_count <= '0;
            result    <= '0;
            overflow  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= (state_q == ST_LATCH);
            if (state_q == ST_LATCH) begin
                raw_count <= tally;
                result    <= corrected;
                overflow  <= tally_sat;
            end
        end
    end

    // R2: while converting, the divider window is open
    assert_gate_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE) |-> gate_open);

    // R5: done lasts a single cycle
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: results stay put between reports
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(state_q == ST_LATCH) |-> $stable(raw_count));

    // R4: the corrected code never exceeds the raw count
    assert_result_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result <= raw_count);

    // R6: a repeated start cannot cut a running window short
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE && !gate_last) |=> (state_q == ST_GATE));

    // R7: overflow is reported only with a saturated count
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (raw_count == CNT_MAX));
endmodule

// File: tb/gated_count_conv_bench.sv
module gated_count_conv_bench;
    localparam int CNT_W  = 10;
    localparam int GATE_W = 16;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int NV     = 8;
    localparam int VLEN [NV] = '{200, 400, 1000, 60, 300, 100, 3000, 150};
    localparam int VPER [NV] = '{4, 2, 5, 3, 10, 20, 2, 0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              pulse_in = 1'b0;
    logic [GATE_W-1:0] gate_len = '0;
    logic [CNT_W-1:0]  raw_count, result;
    logic              overflow, done;

    int n_chk = 0, n_bad = 0, pper = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gated_count_conv #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_gated_count_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .pulse_in(pulse_in),
        .gate_len(gate_len), .raw_count(raw_count), .result(result),
        .overflow(overflow), .done(done)
    );

    // Pulse source: period pper clocks, high for the first half
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (pper == 0) begin pulse_in = 1'b0; ph = 0; end
            else begin
                ph = (ph + 1 >= pper) ? 0 : ph + 1;
                pulse_in = (ph < (pper + 1) / 2) && (ph < pper - 1 || pper == 1);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int corr(input int raw, input int len);
        int z = len / 20;
        return (raw > z) ? raw - z : 0;
    endfunction

    // Wait until done is seen (at a negedge); returns rising edges waited
    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk); cyc++; @(negedge clk);
        end
    endtask

    task automatic launch(input int len);
        @(negedge clk);
        gate_len = GATE_W'(len);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_result(input int len, input int per);
        int e = (per == 0) ? 0 : len / per;
        if (e > CMAX) begin
            check(raw_count == CMAX, "R7 saturated count", raw_count, CMAX);
            check(overflow == 1'b1, "R7 overflow flag", overflow, 1);
        end else begin
            check((raw_count + 1 >= e) && (raw_count <= e + 1), "R3 edge count",
                  raw_count, e);
            check(overflow == 1'b0, "R7 no overflow", overflow, 0);
        end
        check(result == corr(raw_count, len), "R4 corrected result",
              result, corr(raw_count, len));
    endtask

    initial begin
        int cyc;
        #20;
        @(negedge clk);
        check(raw_count == 0 && result == 0, "R1 reset counts", raw_count, 0);
        check(done == 0 && overflow == 0, "R1 reset flags", {done, overflow}, 0);
        rst_n = 1'b1;

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            pper = VPER[i];
            launch(VLEN[i]);
            wait_done(cyc);
            check(cyc == VLEN[i] + 1, "R2 window length", cyc, VLEN[i] + 1);
            check_result(VLEN[i], VPER[i]);
            @(negedge clk);
            check(done == 1'b0, "R5 done one cycle", done, 0);
        end

        // R6/R8: start and gate_len change while running
        pper = 5;
        launch(100);
        repeat (30) @(negedge clk);
        gate_len = GATE_W'(5);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check(cyc == 100 - 31 + 1, "R6 repeated start ignored", cyc, 70);
        check_result(100, 5);
        cyc = 0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (done) cyc++;
        end
        check(cyc == 0, "R6 single done", cyc, 0);

        // R8: zero length acts as one
        pper = 0;
        launch(0);
        wait_done(cyc);
        check(cyc == 2, "R8 zero length", cyc, 2);
        check(raw_count == 0 && result == 0, "R8 zero-length counts", raw_count, 0);

        // R9: start in the done cycle is accepted
        pper = 4;
        launch(80);
        wait_done(cyc);
        check(cyc == 81, "R2 first of pair", cyc, 81);
        gate_len = GATE_W'(120);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc);
        check(cyc == 121, "R9 start with done accepted", cyc, 121);
        check_result(120, 4);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule